// File: doc/BRIEF.md
# Chained DMA Descriptor List Parser

This block walks a chain of DMA job descriptors kept in memory and hands each decoded job to a separate transfer engine. A session starts with a pulse on `start` that carries a 16-bit list pointer, a fixed upper address part and a mode choice. The parser then reads the list one byte at a time through a simple request/response port. Each descriptor is turned into its command, length, source, target and modulo fields, and those fields are offered on a valid/ready handshake. The parser waits for the engine to report completion. If the descriptor's chain flag is set, it continues with the bytes that directly follow.

Two descriptor layouts exist: a compact 11-byte one and a 12-byte one with an extra subcommand byte. The two layouts place the per-channel mode flags differently. In extended mode, every descriptor is preceded by a zero-terminated list of option codes. These codes can switch the layout, set upper address bytes, set step rates and control a transparent value. Option settings persist along one chain and are reset when a new session starts.

Top module: `dmaListParser`

## Requirements
- R1: After reset, `busy`, `rdReq` and `descValid` are low.
- R2: After `start`, list bytes are read from `{startUpper, ptr}`. `ptr` begins at `startAddr` and advances by exactly one per byte consumed, wrapping within 16 bits while the upper part stays fixed. Only one read is outstanding at a time, and every read ends with one `rdValid` cycle.
- R3: Layout A (11 bytes, in this order: command, count low, count high, source low/mid/high, target low/mid/high, modulo low, modulo high) is decoded as follows. Command bits 1:0 give the command, bit 2 gives chain, and bits 7:4 give the minterm. In each address high byte, bits 7:4 give the channel mode {io, dec, mod, hold} and bits 3:0 give address bits 19:16. The bank output is 0.
- R4: Layout B (12 bytes) inserts a subcommand byte after the target high byte. Bit 7 of each address high byte is io and bits 6:4 are the bank. Source and target decrement come from command bits 4 and 5. Subcommand bits 0/1/2/3 give source mod, source hold, target mod and target hold. The minterm output is 0.
- R5: `descValid` stays high with all descriptor fields unchanged until `descReady`. No list read is issued while a descriptor is presented or while its job runs.
- R6: After `jobDone`, a descriptor with chain = 1 causes the next descriptor to be fetched from the byte that follows it. With chain = 0, the block returns to idle and issues no further reads.
- R7: In extended mode, every descriptor, including each chained one, is preceded by option bytes. A zero byte ends the option list.
- R8: Option codes: 0x0A selects layout A and 0x0B selects layout B. 0x80/0x81 set the source/target megabyte. 0x82/0x83 set the source/target step fraction and 0x84/0x85 set the source/target step integer; each step output is {integer, fraction}. 0x86 enables transparency, 0x06 disables it, and 0x87 sets the transparent value. The codes 0x80 to 0x85 and 0x87 each take one parameter byte.
- R9: Option state carries over to chained descriptors. Each new session starts with layout = `defaultLayoutB`, megabytes 0, steps 0x0100, and transparency off with value 0.
- R10: Unknown codes with bit 7 clear are ignored and take no parameter. Unknown codes with bit 7 set skip one parameter byte. Neither kind changes any output.
- R11: Outside extended mode, descriptors follow one another with no option bytes, use `defaultLayoutB`, and present the default option values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Session start pulse, accepted while idle |
| startAddr | input | 16 | First list byte address |
| startUpper | input | 8 | Fixed upper address part for list reads |
| startExt | input | 1 | Session uses option preambles |
| defaultLayoutB | input | 1 | Layout used unless overridden |
| rdReq | output | 1 | One-cycle read request |
| rdAddr | output | 24 | Read byte address |
| rdValid | input | 1 | Read data valid |
| rdData | input | 8 | Read data |
| descValid | output | 1 | Decoded descriptor offered |
| descReady | input | 1 | Engine accepts descriptor |
| descLayoutB | output | 1 | Layout the descriptor was read with |
| descCmd | output | 2 | Command code |
| descChain | output | 1 | Chain flag |
| descMinterm | output | 4 | Logic-mix selector (layout A) |
| descCount | output | 16 | Transfer count |
| descModulo | output | 16 | Modulo value |
| descSrcAddr | output | 20 | Source address bits 19:0 |
| descSrcMode | output | 4 | Source {io, dec, mod, hold} |
| descSrcBank | output | 3 | Source bank (layout B) |
| descSrcMb | output | 8 | Source address bits 27:20 |
| descSrcStep | output | 16 | Source step {integer, fraction} |
| descDstAddr | output | 20 | Target address bits 19:0 |
| descDstMode | output | 4 | Target {io, dec, mod, hold} |
| descDstBank | output | 3 | Target bank (layout B) |
| descDstMb | output | 8 | Target address bits 27:20 |
| descDstStep | output | 16 | Target step {integer, fraction} |
| descTransEn | output | 1 | Transparency enabled |
| descTransVal | output | 8 | Transparent byte value |
| jobDone | input | 1 | Engine finished current job |
| busy | output | 1 | Session in progress |

## Verification
Some properties are checked on every cycle: there is never more than one read in flight, the list pointer advances by exactly one per consumed byte, the upper address part stays fixed for the whole session, and the option state stays frozen while descriptor bytes arrive. The same applies to a presented descriptor, which must hold its valid and every field until accepted. What only the scenarios can show is whether bytes land in the correct fields for each layout. The scenarios also cover the exact read address sequence across a 16-bit wrap, option inheritance and skipped unknown codes along a chain, the reset of options at a new session, and the absence of reads after the final job.

// File: rtl/dlp_pkg.sv
package dlp_pkg;
  localparam int NUM_SLOTS = 12;
  localparam logic [3:0] LAST_A    = 4'd10;
  localparam logic [3:0] LAST_B    = 4'd11;
  localparam logic [3:0] MOD_A_IDX = 4'd9;

  localparam logic [7:0] OPT_LAY_A     = 8'h0A;
  localparam logic [7:0] OPT_LAY_B     = 8'h0B;
  localparam logic [7:0] OPT_TRANS_OFF = 8'h06;
  localparam logic [7:0] OPT_TRANS_ON  = 8'h86;
  localparam logic [7:0] OPT_SRC_MB    = 8'h80;
  localparam logic [7:0] OPT_DST_MB    = 8'h81;
  localparam logic [7:0] OPT_SRC_FRAC  = 8'h82;
  localparam logic [7:0] OPT_DST_FRAC  = 8'h83;
  localparam logic [7:0] OPT_SRC_INT   = 8'h84;
  localparam logic [7:0] OPT_DST_INT   = 8'h85;
  localparam logic [7:0] OPT_TRANS_VAL = 8'h87;

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_WAIT, S_SHOW, S_RUN} state_t;
  typedef enum logic [1:0] {PH_OPT, PH_PARAM, PH_DESC} phase_t;

  typedef struct packed {
    logic       startSess;
    logic       takeByte;
    logic       optByte;
    logic       paramByte;
    logic       descByte;
    logic [3:0] slot;
  } dlpStrobe_t;
endpackage

// File: rtl/dlpCtrl.sv
module dlpCtrl
  import dlp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       startExt,
  input  logic       rdValid,
  input  logic [7:0] rdData,
  input  logic       layoutB,
  input  logic       chainBit,
  input  logic       descReady,
  input  logic       jobDone,
  output logic       rdReq,
  output logic       descValid,
  output logic       busy,
  output dlpStrobe_t strb
);
  state_t     state;
  phase_t     phase;
  logic [3:0] idx;
  logic       extMode;
  logic [3:0] lastIdx;
  logic       needParam;

  assign lastIdx   = layoutB ? LAST_B : LAST_A;
  assign needParam = rdData[7] && (rdData != OPT_TRANS_ON);

  always_comb begin
    strb           = '0;
    strb.slot      = (!layoutB && idx >= MOD_A_IDX) ? idx + 4'd1 : idx;
    strb.startSess = (state == S_IDLE) && start;
    if (state == S_WAIT && rdValid) begin
      strb.takeByte  = 1'b1;
      strb.optByte   = (phase == PH_OPT) && (rdData != 8'h00);
      strb.paramByte = (phase == PH_PARAM);
      strb.descByte  = (phase == PH_DESC);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      phase   <= PH_DESC;
      idx     <= '0;
      extMode <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: if (start) begin
          extMode <= startExt;
          phase   <= startExt ? PH_OPT : PH_DESC;
          idx     <= '0;
          state   <= S_REQ;
        end
        S_REQ: state <= S_WAIT;
        S_WAIT: if (rdValid) begin
          state <= S_REQ;
          unique case (phase)
            PH_OPT: begin
              if (rdData == 8'h00) begin
                phase <= PH_DESC;
                idx   <= '0;
              end else if (needParam) begin
                phase <= PH_PARAM;
              end
            end
            PH_PARAM: phase <= PH_OPT;
            default: begin
              if (idx == lastIdx) state <= S_SHOW;
              else idx <= idx + 4'd1;
            end
          endcase
        end
        S_SHOW: if (descReady) state <= S_RUN;
        S_RUN: if (jobDone) begin
          if (chainBit) begin
            phase <= extMode ? PH_OPT : PH_DESC;
            idx   <= '0;
            state <= S_REQ;
          end else begin
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign rdReq     = (state == S_REQ);
  assign descValid = (state == S_SHOW);
  assign busy      = (state != S_IDLE);

  // R2
  single_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |=> !rdReq);

  // R5
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    descValid && !descReady |=> descValid);
endmodule

// File: rtl/dlpData.sv
module dlpData
  import dlp_pkg::*;
#(
  parameter int PTR_W   = 16,
  parameter int UPPER_W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  dlpStrobe_t               strb,
  input  logic [PTR_W-1:0]         startAddr,
  input  logic [UPPER_W-1:0]       startUpper,
  input  logic                     defaultLayoutB,
  input  logic [7:0]               rdData,
  output logic [UPPER_W+PTR_W-1:0] rdAddr,
  output logic                     layoutB,
  output logic                     chainBit,
  output logic [1:0]               descCmd,
  output logic [3:0]               descMinterm,
  output logic [15:0]              descCount,
  output logic [15:0]              descModulo,
  output logic [19:0]              descSrcAddr,
  output logic [3:0]               descSrcMode,
  output logic [2:0]               descSrcBank,
  output logic [7:0]               descSrcMb,
  output logic [15:0]              descSrcStep,
  output logic [19:0]              descDstAddr,
  output logic [3:0]               descDstMode,
  output logic [2:0]               descDstBank,
  output logic [7:0]               descDstMb,
  output logic [15:0]              descDstStep,
  output logic                     descTransEn,
  output logic [7:0]               descTransVal
);
  logic [PTR_W-1:0]   ptr;
  logic [UPPER_W-1:0] upper;
  logic [7:0]         optCode;
  logic [7:0]         srcMb, dstMb, srcFrac, dstFrac, srcInt, dstInt, transVal;
  logic               transEn;
  logic [NUM_SLOTS-1:0][7:0] raw;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr <= '0; upper <= '0; optCode <= '0; layoutB <= 1'b0;
      srcMb <= '0; dstMb <= '0; srcFrac <= '0; dstFrac <= '0;
      srcInt <= 8'd1; dstInt <= 8'd1; transEn <= 1'b0; transVal <= '0;
    end else if (strb.startSess) begin
      ptr <= startAddr; upper <= startUpper; layoutB <= defaultLayoutB;
      srcMb <= '0; dstMb <= '0; srcFrac <= '0; dstFrac <= '0;
      srcInt <= 8'd1; dstInt <= 8'd1; transEn <= 1'b0; transVal <= '0;
    end else begin
      if (strb.takeByte) ptr <= ptr + 1'b1;
      if (strb.optByte) begin
        optCode <= rdData;
        case (rdData)
          OPT_LAY_A:     layoutB <= 1'b0;
          OPT_LAY_B:     layoutB <= 1'b1;
          OPT_TRANS_ON:  transEn <= 1'b1;
          OPT_TRANS_OFF: transEn <= 1'b0;
          default: ;
        endcase
      end
      if (strb.paramByte) begin
        case (optCode)
          OPT_SRC_MB:    srcMb    <= rdData;
          OPT_DST_MB:    dstMb    <= rdData;
          OPT_SRC_FRAC:  srcFrac  <= rdData;
          OPT_DST_FRAC:  dstFrac  <= rdData;
          OPT_SRC_INT:   srcInt   <= rdData;
          OPT_DST_INT:   dstInt   <= rdData;
          OPT_TRANS_VAL: transVal <= rdData;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) raw <= '0;
    else if (strb.descByte) begin
      for (int s = 0; s < NUM_SLOTS; s++)
        if (strb.slot == 4'(s)) raw[s] <= rdData;
    end
  end

  assign rdAddr   = {upper, ptr};
  assign chainBit = raw[0][2];

  always_comb begin
    descCmd     = raw[0][1:0];
    descCount   = {raw[2], raw[1]};
    descSrcAddr = {raw[5][3:0], raw[4], raw[3]};
    descDstAddr = {raw[8][3:0], raw[7], raw[6]};
    descModulo  = {raw[11], raw[10]};
    if (layoutB) begin
      descMinterm = 4'd0;
      descSrcMode = {raw[5][7], raw[0][4], raw[9][0], raw[9][1]};
      descDstMode = {raw[8][7], raw[0][5], raw[9][2], raw[9][3]};
      descSrcBank = raw[5][6:4];
      descDstBank = raw[8][6:4];
    end else begin
      descMinterm = raw[0][7:4];
      descSrcMode = raw[5][7:4];
      descDstMode = raw[8][7:4];
      descSrcBank = 3'd0;
      descDstBank = 3'd0;
    end
  end

  assign descSrcMb    = srcMb;
  assign descDstMb    = dstMb;
  assign descSrcStep  = {srcInt, srcFrac};
  assign descDstStep  = {dstInt, dstFrac};
  assign descTransEn  = transEn;
  assign descTransVal = transVal;

  // R2
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.takeByte |=> ptr == $past(ptr) + 1'b1);

  // R9
  opts_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.descByte |=> $stable(srcMb) && $stable(dstMb) && $stable(transEn)
                      && $stable(transVal) && $stable(srcInt) && $stable(dstFrac));
endmodule

// File: rtl/dmaListParser.sv
module dmaListParser
  import dlp_pkg::*;
#(
  parameter int PTR_W   = 16,
  parameter int UPPER_W = 8,
  localparam int ADDR_W = PTR_W + UPPER_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [PTR_W-1:0]   startAddr,
  input  logic [UPPER_W-1:0] startUpper,
  input  logic               startExt,
  input  logic               defaultLayoutB,
  output logic               rdReq,
  output logic [ADDR_W-1:0]  rdAddr,
  input  logic               rdValid,
  input  logic [7:0]         rdData,
  output logic               descValid,
  input  logic               descReady,
  output logic               descLayoutB,
  output logic [1:0]         descCmd,
  output logic               descChain,
  output logic [3:0]         descMinterm,
  output logic [15:0]        descCount,
  output logic [15:0]        descModulo,
  output logic [19:0]        descSrcAddr,
  output logic [3:0]         descSrcMode,
  output logic [2:0]         descSrcBank,
  output logic [7:0]         descSrcMb,
  output logic [15:0]        descSrcStep,
  output logic [19:0]        descDstAddr,
  output logic [3:0]         descDstMode,
  output logic [2:0]         descDstBank,
  output logic [7:0]         descDstMb,
  output logic [15:0]        descDstStep,
  output logic               descTransEn,
  output logic [7:0]         descTransVal,
  input  logic               jobDone,
  output logic               busy
);
  dlpStrobe_t strb;
  logic       layoutB, chainBit;

  dlpCtrl i_ctrl (
    .clk, .rstN, .start, .startExt, .rdValid, .rdData,
    .layoutB, .chainBit, .descReady, .jobDone,
    .rdReq, .descValid, .busy, .strb
  );

  dlpData #(.PTR_W(PTR_W), .UPPER_W(UPPER_W)) i_data (
    .clk, .rstN, .strb, .startAddr, .startUpper, .defaultLayoutB, .rdData,
    .rdAddr, .layoutB, .chainBit,
    .descCmd, .descMinterm, .descCount, .descModulo,
    .descSrcAddr, .descSrcMode, .descSrcBank, .descSrcMb, .descSrcStep,
    .descDstAddr, .descDstMode, .descDstBank, .descDstMb, .descDstStep,
    .descTransEn, .descTransVal
  );

  assign descLayoutB = layoutB;
  assign descChain   = chainBit;

  // R5
  fields_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    descValid && !descReady |=> $stable(descCount) && $stable(descSrcAddr)
      && $stable(descDstAddr) && $stable(descModulo) && $stable(descSrcMode)
      && $stable(descDstMode) && $stable(descCmd) && $stable(descChain));

  // R2
  upper_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy && $past(busy) |-> $stable(rdAddr[ADDR_W-1:PTR_W]));
endmodule

// File: tb/test_dmaListParser.sv
`timescale 1ns/1ps
module test_dmaListParser;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 0, startExt = 0, defaultLayoutB = 0;
  logic [15:0] startAddr = '0;
  logic [7:0]  startUpper = '0;
  logic rdReq, rdValid = 0;
  logic [23:0] rdAddr;
  logic [7:0]  rdData = '0;
  logic descValid, descReady = 0, jobDone = 0, busy;
  logic descLayoutB, descChain, descTransEn;
  logic [1:0] descCmd;
  logic [3:0] descMinterm, descSrcMode, descDstMode;
  logic [15:0] descCount, descModulo, descSrcStep, descDstStep;
  logic [19:0] descSrcAddr, descDstAddr;
  logic [2:0] descSrcBank, descDstBank;
  logic [7:0] descSrcMb, descDstMb, descTransVal;

  always #5 clk = ~clk;

  dmaListParser i_dmaListParser (.*);

  typedef struct packed {
    logic lb; logic [1:0] cmd; logic chain; logic [3:0] mint;
    logic [15:0] cnt; logic [15:0] md;
    logic [19:0] sa; logic [3:0] sm; logic [2:0] sb; logic [7:0] smb; logic [15:0] sst;
    logic [19:0] da; logic [3:0] dm; logic [2:0] db; logic [7:0] dmb; logic [15:0] dst;
    logic te; logic [7:0] tv;
  } exp_t;

  int nChecks = 0, nFails = 0;
  bit done = 0;
  logic [7:0] mem [int];
  logic [23:0] expAddr [$];
  exp_t expDesc [$];
  string expTag [$];
  logic [7:0] curUpper;
  logic [15:0] wp;
  logic eLB, eTe;
  logic [7:0] eSmb, eDmb, eTv;
  logic [15:0] eSst, eDst;
  bit fetchDuringShow = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic putByte(input logic [7:0] v);
    mem[int'({curUpper, wp})] = v;
    expAddr.push_back({curUpper, wp});
    wp = wp + 16'd1;
  endtask

  task automatic defaults(input logic b);
    eLB = b; eSmb = 0; eDmb = 0; eSst = 16'h0100; eDst = 16'h0100; eTe = 0; eTv = 0;
  endtask

  task automatic putDesc(input string tag, input logic [1:0] cmd, input logic chain,
      input logic [3:0] mint, input logic [15:0] cnt,
      input logic [19:0] sa, input logic [3:0] sm, input logic [2:0] sb,
      input logic [19:0] da, input logic [3:0] dm, input logic [2:0] db,
      input logic [15:0] md);
    exp_t e;
    logic b;
    b = eLB;
    if (b) putByte({2'b00, dm[2], sm[2], 1'b0, chain, cmd});
    else   putByte({mint, 1'b0, chain, cmd});
    putByte(cnt[7:0]); putByte(cnt[15:8]);
    putByte(sa[7:0]); putByte(sa[15:8]);
    putByte(b ? {sm[3], sb, sa[19:16]} : {sm, sa[19:16]});
    putByte(da[7:0]); putByte(da[15:8]);
    putByte(b ? {dm[3], db, da[19:16]} : {dm, da[19:16]});
    if (b) putByte({4'b0, dm[0], dm[1], sm[0], sm[1]});
    putByte(md[7:0]); putByte(md[15:8]);
    e = '{lb: b, cmd: cmd, chain: chain, mint: b ? 4'd0 : mint, cnt: cnt, md: md,
          sa: sa, sm: sm, sb: b ? sb : 3'd0, smb: eSmb, sst: eSst,
          da: da, dm: dm, db: b ? db : 3'd0, dmb: eDmb, dst: eDst, te: eTe, tv: eTv};
    expDesc.push_back(e);
    expTag.push_back(tag);
  endtask

  function automatic exp_t sampleOut();
    return '{lb: descLayoutB, cmd: descCmd, chain: descChain, mint: descMinterm,
             cnt: descCount, md: descModulo, sa: descSrcAddr, sm: descSrcMode,
             sb: descSrcBank, smb: descSrcMb, sst: descSrcStep, da: descDstAddr,
             dm: descDstMode, db: descDstBank, dmb: descDstMb, dst: descDstStep,
             te: descTransEn, tv: descTransVal};
  endfunction

  // memory responder, latency alternating 1 and 3 cycles
  initial begin
    int cnt = 0, lat = 1;
    logic [23:0] a = '0;
    forever begin
      @(negedge clk);
      rdValid = 0;
      if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin
          rdValid = 1;
          rdData = mem.exists(int'(a)) ? mem[int'(a)] : 8'h00;
        end
      end
      if (rdReq) begin
        if (descValid) fetchDuringShow = 1;
        if (expAddr.size() == 0) check(0, "R6", "unexpected read", rdAddr, 0);
        else begin
          logic [23:0] ea;
          ea = expAddr.pop_front();
          check(rdAddr == ea, "R2", "read address", rdAddr, ea);
        end
        a = rdAddr; cnt = lat; lat = (lat == 1) ? 3 : 1;
      end
    end
  end

  // engine model and scoreboard monitor
  initial begin
    int hold = 0, doneCnt = 0;
    bit sel = 0;
    forever begin
      @(negedge clk);
      jobDone = 0;
      if (descReady) begin
        descReady = 0; doneCnt = 3;
      end else if (descValid) begin
        if (rdReq) fetchDuringShow = 1;
        if (hold == 0) begin
          exp_t got, ex;
          string tg;
          got = sampleOut();
          if (expDesc.size() == 0) check(0, "R6", "unexpected descriptor", got, 0);
          else begin
            ex = expDesc.pop_front(); tg = expTag.pop_front();
            check(got == ex, tg, "descriptor fields", got, ex);
          end
          descReady = 1;
          sel = !sel; hold = sel ? 2 : 0;
        end else hold--;
      end
      if (doneCnt > 0) begin
        doneCnt--;
        if (doneCnt == 0) jobDone = 1;
      end
    end
  end

  task automatic doStart(input logic [15:0] a, input logic ext, input logic defB);
    @(negedge clk);
    startAddr = a; startUpper = curUpper; startExt = ext; defaultLayoutB = defB; start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic waitIdleAndDrain(input string tag);
    int n = 0;
    while (busy && n < 5000) begin @(negedge clk); n++; end
    repeat (8) @(negedge clk);
    check(!busy, tag, "idle after last job", busy, 0);
    check(expAddr.size() == 0 && expDesc.size() == 0, tag, "all reads and jobs consumed",
          expAddr.size() + expDesc.size(), 0);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "R6", "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    check(!busy && !rdReq && !descValid, "R1", "reset outputs", {busy, rdReq, descValid}, 0);

    // R3 R11: classic mode, single layout A job, chain clear
    curUpper = 8'h12; wp = 16'h0100; defaults(1'b0);
    putDesc("R3", 2'd1, 1'b0, 4'hA, 16'h1234, 20'h5ABCD, 4'b1010, 3'd0,
            20'h9_8765, 4'b0101, 3'd0, 16'hBEEF);
    doStart(16'h0100, 1'b0, 1'b0);
    waitIdleAndDrain("R6");

    // R4 R2 R6: classic layout B chain of two, list wraps through 0xFFFF
    curUpper = 8'h03; wp = 16'hFFF6; defaults(1'b1);
    putDesc("R4", 2'd2, 1'b1, 4'h0, 16'h0010, 20'h1_2345, 4'b1101, 3'd5,
            20'hF_0F0F, 4'b0110, 3'd2, 16'h0102);
    putDesc("R4", 2'd3, 1'b0, 4'h0, 16'hFFFF, 20'h0_0001, 4'b0011, 3'd7,
            20'h7_7777, 4'b1001, 3'd1, 16'h8001);
    doStart(16'hFFF6, 1'b0, 1'b1);
    waitIdleAndDrain("R2");

    // R7 R8 R10 R9: extended chain, options carried and changed
    curUpper = 8'hA5; wp = 16'h2000; defaults(1'b0);
    putByte(8'h0B); putByte(8'h80); putByte(8'h45); putByte(8'h81); putByte(8'h67);
    putByte(8'h82); putByte(8'h40); putByte(8'h85); putByte(8'h03);
    putByte(8'h86); putByte(8'h87); putByte(8'h5A); putByte(8'h00);
    eLB = 1; eSmb = 8'h45; eDmb = 8'h67; eSst = 16'h0140; eDst = 16'h0300;
    eTe = 1; eTv = 8'h5A;
    putDesc("R8", 2'd0, 1'b1, 4'h0, 16'h0200, 20'h0_4000, 4'b0100, 3'd3,
            20'h0_8000, 4'b0000, 3'd4, 16'h0000);
    putByte(8'h0A); putByte(8'h06); putByte(8'h21); putByte(8'h9F); putByte(8'h77);
    putByte(8'h84); putByte(8'h02); putByte(8'h00);
    eLB = 0; eTe = 0; eSst = 16'h0240;
    putDesc("R10", 2'd1, 1'b1, 4'h6, 16'h0003, 20'h3_0000, 4'b0001, 3'd0,
            20'h4_0000, 4'b1000, 3'd0, 16'h0040);
    putByte(8'h00);
    putDesc("R9", 2'd3, 1'b0, 4'hF, 16'h0001, 20'h0_0010, 4'b0000, 3'd0,
            20'h0_0020, 4'b0000, 3'd0, 16'h0000);
    doStart(16'h2000, 1'b1, 1'b0);
    waitIdleAndDrain("R7");

    // R9: new extended session starts from defaults
    curUpper = 8'h00; wp = 16'h0400; defaults(1'b1);
    putByte(8'h00);
    putDesc("R9", 2'd2, 1'b0, 4'h0, 16'h0444, 20'hA_AAAA, 4'b1111, 3'd6,
            20'h5_5555, 4'b1010, 3'd3, 16'hC3C3);
    doStart(16'h0400, 1'b1, 1'b1);
    waitIdleAndDrain("R9");

    // R5: no list read while a descriptor was presented
    check(!fetchDuringShow, "R5", "read issued while descriptor presented", fetchDuringShow, 0);
    summary();
  end
endmodule